// File: doc/BRIEF.md
# Interlocked Two-Path Edge Generator

This block schedules the rising and falling edges of a synthesized clock on a grid of equally spaced phase ticks. One clock cycle of `clk` stands for one phase step, and a free-running phase counter names the phase that is active in each cycle. The work is split into two alternating select paths. The rise path keeps a fixed-point accumulator: 5 integer bits (the phase address) and 5 fraction bits. The fall path keeps only a 5-bit phase address. That address is the rise path's integer address plus a half-period offset, wrapped modulo the number of phases. Because the fall address is derived from the rise address, the high time is fixed by the offset and does not depend on any initial value.

The open and blocked state of the paths is taken from the synthesized output itself. While the output is low, the rise path is open (its select drives the next edge) and the fall path is blocked, so the fall path may reload its select. While the output is high, the roles swap, and the rise path advances its accumulator. Each select is therefore rewritten only while its own path is not driving the output. The rise result is registered before the fall path adds the offset, and the fall sum is registered again, so each adder has a whole output phase to settle.

Top module: `fa_dual_path_gen`

## Requirements
- R1: While `rst_n` is low, `clk_out`, `en_a`, `en_b` and `sel_a` are all 0.
- R2: The first clock edge after reset release loads the fall select and arms the rise path. `clk_out` first goes high on the 33rd clock edge after release, because the phase counter starts at 0 and the rise address starts at phase 0.
- R3: `sel_a` changes only at an edge after which `clk_out` is high (rise path blocked).
- R4: `sel_b` changes only at an edge after which `clk_out` is low (fall path blocked).
- R5: `inc_word` carries the integer phase step in bits [9:5] and the fraction in bits [4:0]. Consecutive rising edges are separated by the integer step plus the carry out of a 5-bit fraction accumulator that starts at 0. The valid ranges are: integer step 2..30, and offset from 1 to one less than the integer step.
- R6: Each high time lasts exactly `half_off` cycles, using the value sampled at the falling edge that precedes it (or at the first edge after release).
- R7: When `clk_out` goes high, `sel_b` equals the phase of that rising edge plus the offset, modulo 32.
- R8: A change of `inc_word` while `clk_out` is high does not alter the next period. It takes effect from the period after.
- R9: A change of `half_off` while `clk_out` is high does not alter the current high time. It applies to the next high time.
- R10: With a zero fraction and an offset of half the integer step (rounded down), the high and low times differ by at most one cycle.
- R11: After the first edge following release, `en_b` equals `clk_out` and `en_a` equals its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-tick clock; one cycle per phase step |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_word | input | 10 | Period step: integer in [9:5], fraction in [4:0] |
| half_off | input | 5 | High time in phase steps, added to the rise address |
| sel_a | output | 5 | Rise path phase select |
| sel_b | output | 5 | Fall path phase select |
| en_a | output | 1 | Rise path open |
| en_b | output | 1 | Fall path open |
| clk_out | output | 1 | Synthesized clock |

## Verification
A rising or falling edge detected at clock edge n is visible on `clk_out` one register later, just after edge n. The bench samples 1 ns after every rising edge of `clk` and numbers the edges from reset release, so the first rise is due in the sample after edge 33. From each observed rise, the bench computes the edge number of the next rise as step plus fraction carry, and the edge number of the fall as rise plus offset. It compares exactly those samples. The inputs seen by the design at an edge are the values held before that sample, and the bench applies changes only after its bookkeeping for that sample. This keeps the R8 and R9 checks aligned with the event that latches each input.

// File: rtl/fa2p_pkg.sv
package fa2p_pkg;
    typedef struct packed {
        logic hi;     // synthesized output level
        logic armed;  // both selects hold valid addresses
    } ctl_t;
endpackage

// File: rtl/fa_phase_ctr.sv
module fa_phase_ctr #(
    parameter int PH_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] ph_o
);
    logic [PH_W-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = ph_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign ph_o = ph_q;
endmodule

// File: rtl/fa_rise_path.sv
module fa_rise_path #(
    parameter int PH_W = 5,
    parameter int FR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_i,
    input  logic [PH_W+FR_W-1:0] inc_i,
    input  logic                 open_i,
    output logic [PH_W-1:0]      sel_o
);
    localparam int ACC_W = PH_W + FR_W;

    logic [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (step_i) acc_d = acc_q + inc_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign sel_o = acc_q[ACC_W-1:FR_W];

    // R3: the rise select never moves while the rise path stays open
    assert_rise_sel_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && $past(open_i)) |-> $stable(sel_o));
endmodule

// File: rtl/fa_fall_path.sv
module fa_fall_path #(
    parameter int PH_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [PH_W-1:0] base_i,
    input  logic [PH_W-1:0] off_i,
    input  logic            open_i,
    output logic [PH_W-1:0] sel_o
);
    logic [PH_W-1:0] sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (load_i) sel_d = base_i + off_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign sel_o = sel_q;

    // R4: the fall select never moves while the fall path stays open
    assert_fall_sel_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && $past(open_i)) |-> $stable(sel_o));
endmodule

// File: rtl/fa_dual_path_gen.sv
module fa_dual_path_gen #(
    parameter int PH_W = 5,
    parameter int FR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PH_W+FR_W-1:0] inc_word,
    input  logic [PH_W-1:0]      half_off,
    output logic [PH_W-1:0]      sel_a,
    output logic [PH_W-1:0]      sel_b,
    output logic                 en_a,
    output logic                 en_b,
    output logic                 clk_out
);
    import fa2p_pkg::*;

    ctl_t            ctl_d, ctl_q;
    logic [PH_W-1:0] ph;
    logic            rise_ev, fall_ev, load_b;

    fa_phase_ctr #(.PH_W(PH_W)) u_ph (
        .clk   (clk),
        .rst_n (rst_n),
        .ph_o  (ph)
    );

    fa_rise_path #(.PH_W(PH_W), .FR_W(FR_W)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (rise_ev),
        .inc_i  (inc_word),
        .open_i (en_a),
        .sel_o  (sel_a)
    );

    fa_fall_path #(.PH_W(PH_W)) u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_b),
        .base_i (sel_a),
        .off_i  (half_off),
        .open_i (en_b),
        .sel_o  (sel_b)
    );

    always_comb begin
        rise_ev = ctl_q.armed && !ctl_q.hi && (ph == sel_a);
        fall_ev = ctl_q.hi && (ph == sel_b);
        load_b  = fall_ev || !ctl_q.armed;
        ctl_d   = ctl_q;
        ctl_d.armed = 1'b1;
        if (rise_ev)      ctl_d.hi = 1'b1;
        else if (fall_ev) ctl_d.hi = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign clk_out = ctl_q.hi;
    assign en_b    = ctl_q.hi;
    assign en_a    = ctl_q.armed && !ctl_q.hi;

    // R2: no edge before both selects are valid
    assert_quiet_until_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.armed |-> !clk_out);

    // R5: a rise lands on the phase the rise select named
    assert_rise_on_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> (ph == PH_W'($past(sel_a) + 1'b1)));

    // R6: a fall lands on the phase the fall select named
    assert_fall_on_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_out) |-> (ph == PH_W'($past(sel_b) + 1'b1)));
endmodule

// File: tb/fa_dual_path_gen_tb.sv
module fa_dual_path_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] inc_word = '0;
    logic [4:0] half_off = '0;
    logic [4:0] sel_a, sel_b;
    logic       en_a, en_b, clk_out;

    int n_chk = 0;
    int n_fail = 0;
    int e = 0;

    always #5 clk = ~clk;

    fa_dual_path_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_word (inc_word),
        .half_off (half_off),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .en_a     (en_a),
        .en_b     (en_b),
        .clk_out  (clk_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, e);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // mode 0: fixed inputs; 1: step change while high; 2: offset change while high
    task automatic run_cfg(input int ii, input int ff, input int oo, input int mode, input int nv);
        int   exp_rise, exp_fall, cur_off, facc, rises, t_r, t_f, p;
        int   tag_next_rise, tag_next_fall;
        logic pa, pb, po;
        logic [4:0] psa, psb;
        rst_n    = 1'b0;
        inc_word = {ii[4:0], ff[4:0]};
        half_off = oo[4:0];
        repeat (3) @(posedge clk);
        #1;
        check(clk_out == 1'b0 && en_a == 1'b0 && en_b == 1'b0 && sel_a == 5'd0,
              "R1", {en_a, en_b, clk_out}, 0);
        rst_n = 1'b1;
        e = 0; exp_rise = 33; exp_fall = -1; cur_off = oo; facc = 0; rises = 0;
        t_r = 0; t_f = 0; tag_next_rise = 0; tag_next_fall = 0;
        po = 1'b0; psa = sel_a; psb = sel_b;
        pa = 1'b0; pb = 1'b0;
        while (rises < 5 && e < 250) begin
            @(posedge clk);
            #1;
            e++;
            if (sel_a != psa) check(clk_out == 1'b1, "R3", clk_out, 1);
            if (sel_b != psb) check(clk_out == 1'b0, "R4", clk_out, 0);
            check(en_b == clk_out && en_a == !clk_out, "R11", {en_a, en_b}, {!clk_out, clk_out});
            if (!po && clk_out) begin
                rises++;
                if (rises == 1)         check(e == exp_rise, "R2", e, exp_rise);
                else if (tag_next_rise) check(e == exp_rise, "R8", e, exp_rise);
                else                    check(e == exp_rise, "R5", e, exp_rise);
                tag_next_rise = 0;
                check(sel_b == 5'((e - 1 + cur_off) % 32), "R7", sel_b, (e - 1 + cur_off) % 32);
                if (rises > 1 && ff == 0 && oo == ii / 2 && mode == 0) begin
                    p = (t_f - t_r) - (e - t_f);
                    check(p >= -1 && p <= 1, "R10", p, 0);
                end
                t_r = e;
                exp_fall = e + cur_off;
                p = int'(inc_word[9:5]) + ((facc + int'(inc_word[4:0])) >> 5);
                facc = (facc + int'(inc_word[4:0])) & 31;
                exp_rise = e + p;
                if (mode == 1 && rises == 2) begin
                    inc_word = {nv[4:0], ff[4:0]};
                    tag_next_rise = 1;
                end
                if (mode == 2 && rises == 2) begin
                    half_off = nv[4:0];
                    tag_next_fall = 1;
                end
            end
            if (po && !clk_out) begin
                if (tag_next_fall) check(e == exp_fall, "R9", e, exp_fall);
                else               check(e == exp_fall, "R6", e, exp_fall);
                tag_next_fall = 0;
                t_f = e;
                cur_off = int'(half_off);
            end
            po = clk_out; psa = sel_a; psb = sel_b;
        end
        check(rises == 5, "R5", rises, 5);
    endtask

    initial begin
        for (int ii = 2; ii <= 30; ii++) begin
            run_cfg(ii, 0, ii / 2, 0, 0);
            run_cfg(ii, 0, 1, 0, 0);
            run_cfg(ii, 0, ii - 1, 0, 0);
            run_cfg(ii, 9, ii / 2, 0, 0);
            run_cfg(ii, 23, ii / 2, 0, 0);
        end
        run_cfg(10, 0, 5, 1, 14);   // R8 step change while high
        run_cfg(13, 11, 6, 1, 7);   // R8 with fraction
        run_cfg(12, 7, 6, 2, 3);    // R9 offset change while high
        run_cfg(20, 0, 10, 2, 17);  // R9 longer offset
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule